// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port in one register. Single-cycle event strobes from the transmitter and receiver set the transmit-empty, transmit-end, receive-full, overrun, framing and parity flags. A DMA engine clears the transmit pair by writing the transmit data register and clears receive-full by reading the receive data register. The register also holds the multiprocessor bit of the last good character and a software bit that supplies the outgoing multiprocessor bit.

Software clears a flag in two steps. It first reads the register, which arms a per-flag qualifier for each clearable flag that reads as 1. The next write then clears every armed flag whose data bit is 0. That write uses up all qualifiers, whatever data it carries. Writes of 1 never change a flag. When a hardware set and a clear reach the same flag in the same cycle, the set is kept.

The register value comes straight from flops, so a read returns the flags as they stand in that cycle. Every change becomes visible on the clock edge that follows its cause.

Top module: `sio_flag_reg`

## Requirements
- R1: After synchronous reset, stat_o is 8'h84: bit 7 (tx empty) and bit 2 (tx end) are 1, and all other bits are 0.
- R2: A write with a 1 in any of bits 7..3 leaves that flag unchanged, even when the flag is armed. Bits 2 and 1 ignore write data.
- R3: A write clears an armed flag in bits 7..3 when its data bit is 0. A flag is armed only by a read that saw it as 1. Any write disarms all flags, so a second write of 0 without a new read changes nothing.
- R4: Bit 7 (tx empty) is set by tx_load_i and held at 1 while te_i is 0. It is cleared by dma_tdr_wr_i or by a software clear of bit 7.
- R5: Bit 2 (tx end) is set by tx_last_i only while bit 7 is 1. It is also set while te_i is 0 and bit 4 is 0. It is cleared by dma_tdr_wr_i and by a software clear of bit 7.
- R6: rx_done_i with bit 6 at 0 and neither error input set makes bit 6 (rx full) go to 1 and captures rx_mpb_i into bit 1. dma_rdr_rd_i clears bit 6.
- R7: rx_done_i while bit 6 is 1 sets bit 5 (overrun). Bits 6, 4, 3 and 1 are left unchanged.
- R8: rx_done_i while bit 6 is 0 sets bit 4 (framing) if rx_stop_bad_i is 1, and bit 3 (parity) if rx_par_bad_i is 1. Bit 6 is not set in that case.
- R9: Bit 0 takes cpu_wdata_i[0] on every write.
- R10: A set event in the same cycle as a DMA or software clear of the same flag leaves that flag at 1.
- R11: stby_i returns bits 7..1 to their reset values (1,0,0,0,0,1,0) and disarms all flags. Bit 0 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_i | input | 1 | Standby entry, flags to reset values |
| te_i | input | 1 | Transmitter enable level |
| cpu_rd_i | input | 1 | Register read strobe, arms flags read as 1 |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | 8 | Write data |
| tx_load_i | input | 1 | Transmit data moved to shift register |
| tx_last_i | input | 1 | Last bit of a character sent |
| rx_done_i | input | 1 | Reception of a character complete |
| rx_stop_bad_i | input | 1 | Stop bit was 0 (with rx_done_i) |
| rx_par_bad_i | input | 1 | Parity mismatch (with rx_done_i) |
| rx_mpb_i | input | 1 | Received multiprocessor bit (with rx_done_i) |
| dma_tdr_wr_i | input | 1 | DMA wrote transmit data register |
| dma_rdr_rd_i | input | 1 | DMA read receive data register |
| stat_o | output | 8 | Register value |

## Verification
Every flag, the captured multiprocessor bit and the software bit change on the first rising edge after the cycle that carries their cause, and a read arms against the value visible in that same cycle. The bench drives each stimulus at a falling edge and pushes the expected register value at that moment. The monitor pops the entry 1 ns after the following rising edge, so each cycle is checked exactly once, one cycle after its cause. Sequences cover read-then-write clears, unarmed writes, writes already disarmed by an earlier write, and same-cycle set/clear collisions.

// File: rtl/sio_flag_pkg.sv
`timescale 1ns/1ps
package sio_flag_pkg;
  localparam int unsigned SR_W   = 8;
  localparam int unsigned B_TXE  = 7;
  localparam int unsigned B_RXF  = 6;
  localparam int unsigned B_OVR  = 5;
  localparam int unsigned B_FRM  = 4;
  localparam int unsigned B_PAR  = 3;
  localparam int unsigned B_TDN  = 2;
  localparam int unsigned B_MPR  = 1;
  localparam int unsigned B_MPT  = 0;
  localparam int unsigned CLR_LO = B_PAR;
  localparam int unsigned CLR_HI = B_TXE;
  localparam logic [SR_W-1:0] SR_INIT = 8'h84;
endpackage

// File: rtl/sio_flag_cell.sv
`timescale 1ns/1ps
module sio_flag_cell #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk) begin
    if (rst || init_i) q_q <= INIT;
    else if (set_i)    q_q <= 1'b1;
    else if (clr_i)    q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R10: a set always survives a simultaneous clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i && !init_i) |=> q_o);
  // R3: without an event the flag keeps its value
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i && !init_i) |=> $stable(q_o));
  // R11: standby returns the reset value
  a_r11_init_value: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (q_o == INIT));
endmodule

// File: rtl/sio_clr_arm.sv
`timescale 1ns/1ps
module sio_clr_arm #(
  parameter int unsigned LO = 3,
  parameter int unsigned HI = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [HI:LO] flags_i,
  input  logic [HI:LO] wdata_i,
  output logic [HI:LO] clr_o
);
  logic [HI:LO] arm_q;

  always_ff @(posedge clk) begin
    if (rst || init_i) arm_q <= '0;
    else if (rd_i)     arm_q <= flags_i;
    else if (wr_i)     arm_q <= '0;
  end

  assign clr_o = wr_i ? (arm_q & ~wdata_i) : '0;

  // R3: a write without a read in the same cycle leaves nothing armed
  a_r3_write_consumes: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !rd_i) |=> (clr_o == '0));
  // R3: only flags seen as 1 by the read may be cleared afterwards
  a_r3_only_read_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !init_i) |=> ((clr_o & ~$past(flags_i)) == '0));
endmodule

// File: rtl/sio_evt_decode.sv
`timescale 1ns/1ps
module sio_evt_decode (
  input  logic       te_i,
  input  logic       tx_load_i,
  input  logic       tx_last_i,
  input  logic       rx_done_i,
  input  logic       rx_stop_bad_i,
  input  logic       rx_par_bad_i,
  input  logic       dma_tdr_wr_i,
  input  logic       dma_rdr_rd_i,
  input  logic       txe_i,
  input  logic       rxf_i,
  input  logic       frm_i,
  input  logic [7:3] sw_clr_i,
  output logic [7:2] set_o,
  output logic [7:2] clr_o,
  output logic       rx_ok_o
);
  logic rx_new;

  always_comb begin
    rx_new  = rx_done_i && !rxf_i;
    rx_ok_o = rx_new && !rx_stop_bad_i && !rx_par_bad_i;

    set_o[7] = !te_i || tx_load_i;
    set_o[6] = rx_ok_o;
    set_o[5] = rx_done_i && rxf_i;
    set_o[4] = rx_new && rx_stop_bad_i;
    set_o[3] = rx_new && rx_par_bad_i;
    set_o[2] = (tx_last_i && txe_i) || (!te_i && !frm_i);

    clr_o[7] = dma_tdr_wr_i || sw_clr_i[7];
    clr_o[6] = dma_rdr_rd_i || sw_clr_i[6];
    clr_o[5] = sw_clr_i[5];
    clr_o[4] = sw_clr_i[4];
    clr_o[3] = sw_clr_i[3];
    clr_o[2] = dma_tdr_wr_i || sw_clr_i[7];
  end
endmodule

// File: rtl/sio_flag_reg.sv
`timescale 1ns/1ps
module sio_flag_reg
  import sio_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            stby_i,
  input  logic            te_i,
  input  logic            cpu_rd_i,
  input  logic            cpu_wr_i,
  input  logic [SR_W-1:0] cpu_wdata_i,
  input  logic            tx_load_i,
  input  logic            tx_last_i,
  input  logic            rx_done_i,
  input  logic            rx_stop_bad_i,
  input  logic            rx_par_bad_i,
  input  logic            rx_mpb_i,
  input  logic            dma_tdr_wr_i,
  input  logic            dma_rdr_rd_i,
  output logic [SR_W-1:0] stat_o
);
  logic [CLR_HI:CLR_LO] sw_clr;
  logic [7:2]           flag_set, flag_clr, flag_q;
  logic                 rx_ok;
  logic                 mpr_q, mpt_q;
  logic                 unused_wbits;

  assign unused_wbits = ^cpu_wdata_i[B_TDN:B_MPR];

  sio_clr_arm #(.LO(CLR_LO), .HI(CLR_HI)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .init_i  (stby_i),
    .rd_i    (cpu_rd_i),
    .wr_i    (cpu_wr_i),
    .flags_i (stat_o[CLR_HI:CLR_LO]),
    .wdata_i (cpu_wdata_i[CLR_HI:CLR_LO]),
    .clr_o   (sw_clr)
  );

  sio_evt_decode u_dec (
    .te_i          (te_i),
    .tx_load_i     (tx_load_i),
    .tx_last_i     (tx_last_i),
    .rx_done_i     (rx_done_i),
    .rx_stop_bad_i (rx_stop_bad_i),
    .rx_par_bad_i  (rx_par_bad_i),
    .dma_tdr_wr_i  (dma_tdr_wr_i),
    .dma_rdr_rd_i  (dma_rdr_rd_i),
    .txe_i         (flag_q[B_TXE]),
    .rxf_i         (flag_q[B_RXF]),
    .frm_i         (flag_q[B_FRM]),
    .sw_clr_i      (sw_clr),
    .set_o         (flag_set),
    .clr_o         (flag_clr),
    .rx_ok_o       (rx_ok)
  );

  for (genvar i = B_TDN; i <= B_TXE; i++) begin : g_flag
    sio_flag_cell #(.INIT(SR_INIT[i])) u_cell (
      .clk    (clk),
      .rst    (rst),
      .init_i (stby_i),
      .set_i  (flag_set[i]),
      .clr_i  (flag_clr[i]),
      .q_o    (flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || stby_i) mpr_q <= SR_INIT[B_MPR];
    else if (rx_ok)    mpr_q <= rx_mpb_i;
  end

  always_ff @(posedge clk) begin
    if (rst)           mpt_q <= SR_INIT[B_MPT];
    else if (cpu_wr_i) mpt_q <= cpu_wdata_i[B_MPT];
  end

  assign stat_o = {flag_q, mpr_q, mpt_q};

  // R4: transmitter disabled keeps tx empty high
  a_r4_te_low_txe: assert property (@(posedge clk) disable iff (rst)
    !te_i |=> stat_o[B_TXE]);
  // R7: overrun leaves rx full and the captured bit alone
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (rx_done_i && stat_o[B_RXF] && !dma_rdr_rd_i && !stby_i)
    |=> (stat_o[B_OVR] && stat_o[B_RXF] && $stable(stat_o[B_MPR])));
  // R6: a clean character sets rx full and captures its bit
  a_r6_rx_capture: assert property (@(posedge clk) disable iff (rst)
    (rx_done_i && !stat_o[B_RXF] && !rx_stop_bad_i && !rx_par_bad_i && !stby_i)
    |=> (stat_o[B_RXF] && stat_o[B_MPR] == $past(rx_mpb_i)));
  // R9: the software bit follows the written data
  a_r9_mpt_write: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_i |=> (stat_o[B_MPT] == $past(cpu_wdata_i[B_MPT])));
endmodule

// File: tb/sio_flag_reg_bench.sv
`timescale 1ns/1ps
module sio_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stby_i = 1'b0, te_i = 1'b1;
  logic       cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
  logic [7:0] cpu_wdata_i = 8'h00;
  logic       tx_load_i = 1'b0, tx_last_i = 1'b0;
  logic       rx_done_i = 1'b0, rx_stop_bad_i = 1'b0, rx_par_bad_i = 1'b0, rx_mpb_i = 1'b0;
  logic       dma_tdr_wr_i = 1'b0, dma_rdr_rd_i = 1'b0;
  logic [7:0] stat_o;

  typedef struct { logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sbq[$];
  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sio_flag_reg u_sio_flag_reg (
    .clk(clk), .rst(rst), .stby_i(stby_i), .te_i(te_i),
    .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i),
    .tx_load_i(tx_load_i), .tx_last_i(tx_last_i),
    .rx_done_i(rx_done_i), .rx_stop_bad_i(rx_stop_bad_i),
    .rx_par_bad_i(rx_par_bad_i), .rx_mpb_i(rx_mpb_i),
    .dma_tdr_wr_i(dma_tdr_wr_i), .dma_rdr_rd_i(dma_rdr_rd_i),
    .stat_o(stat_o)
  );

  // monitor: one scoreboard entry per cycle, due one edge after its stimulus
  always @(posedge clk) begin
    #1;
    if (sbq.size() != 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      vectors++;
      if (stat_o !== it.exp) begin
        fails++;
        $display("FAIL %s: stat_o=%02h expected=%02h", it.tag, stat_o, it.exp);
      end
    end
  end

  task automatic idle();
    stby_i = 1'b0; cpu_rd_i = 1'b0; cpu_wr_i = 1'b0; cpu_wdata_i = 8'h00;
    tx_load_i = 1'b0; tx_last_i = 1'b0; rx_done_i = 1'b0;
    rx_stop_bad_i = 1'b0; rx_par_bad_i = 1'b0; rx_mpb_i = 1'b0;
    dma_tdr_wr_i = 1'b0; dma_rdr_rd_i = 1'b0;
  endtask

  // driver: inputs already set at this falling edge; push expectation, advance
  task automatic go(input string tag, input logic [7:0] exp);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input string tag, input logic [7:0] exp);
    cpu_rd_i = 1'b1; go(tag, exp);
  endtask

  task automatic wr(input string tag, input logic [7:0] d, input logic [7:0] exp);
    cpu_wr_i = 1'b1; cpu_wdata_i = d; go(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    go("R1 reset value", 8'h84);
    dma_tdr_wr_i = 1'b1;              go("R4 dma write clears txe, R5 tend", 8'h00);
    tx_last_i = 1'b1;                 go("R5 tx_last with txe low ignored", 8'h00);
    tx_load_i = 1'b1;                 go("R4 tx_load sets txe", 8'h80);
    tx_last_i = 1'b1;                 go("R5 tx_last sets tend", 8'h84);
    wr("R3 unarmed write 0 keeps flags", 8'h00, 8'h84);
    wr("R9 write sets mpt", 8'hFF, 8'h85);
    rd("R3 read arms", 8'h85);
    wr("R2 write of ones ignored while armed", 8'hFF, 8'h85);
    rd("R3 read arms again", 8'h85);
    wr("R3 R5 clear txe and tend", 8'h7F, 8'h01);
    tx_load_i = 1'b1;                 go("R4 tx_load after clear", 8'h81);
    wr("R3 write consumed qualifier", 8'h7F, 8'h81);
    wr("R9 write clears mpt", 8'h00, 8'h80);
    rx_done_i = 1'b1; rx_mpb_i = 1'b1; go("R6 clean receive and mpb", 8'hC2);
    rx_done_i = 1'b1; rx_stop_bad_i = 1'b1; go("R7 overrun only", 8'hE2);
    dma_rdr_rd_i = 1'b1;              go("R6 dma read clears rxf", 8'hA2);
    rx_done_i = 1'b1; rx_stop_bad_i = 1'b1; rx_par_bad_i = 1'b1;
                                      go("R8 framing and parity errors", 8'hBA);
    rd("R3 read with errors", 8'hBA);
    wr("R3 clear overrun only", 8'hDE, 8'h9A);
    rd("R10 arm before collision", 8'h9A);
    cpu_wr_i = 1'b1; cpu_wdata_i = 8'h00; rx_done_i = 1'b1; rx_par_bad_i = 1'b1;
                                      go("R10 parity set beats clear", 8'h0A);
    tx_load_i = 1'b1; dma_tdr_wr_i = 1'b1; go("R10 tx_load beats dma clear", 8'h8A);
    te_i = 1'b0;                      go("R4 R5 te low sets tend", 8'h8E);
    dma_tdr_wr_i = 1'b1;              go("R4 te low holds txe over dma", 8'h8E);
    te_i = 1'b1;                      go("R4 te high idle", 8'h8E);
    dma_tdr_wr_i = 1'b1;              go("R4 dma clears txe", 8'h0A);
    rx_done_i = 1'b1; rx_stop_bad_i = 1'b1; go("R8 framing error", 8'h1A);
    te_i = 1'b0;                      go("R5 te low with framing keeps tend", 8'h9A);
    te_i = 1'b1;                      go("R5 te high again", 8'h9A);
    wr("R9 set mpt", 8'h01, 8'h9B);
    stby_i = 1'b1;                    go("R11 standby values", 8'h85);
    rd("R11 read after standby", 8'h85);
    wr("R2 bits 2 and 1 ignore writes", 8'h81, 8'h85);
    @(posedge clk); #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule